// File: doc/BRIEF.md
# Ping-Pong Capture Writer

This block turns a serial stream of generated bits into fixed-width words and stores them in a dual-port RAM that acts as a two-bank ping-pong buffer. Bits come with a valid strobe, most significant bit first. Each completed word goes to the next address of the write port. The address wraps from the last location back to zero, so capture never has to stop for the reader.

A second, independent read port belongs to an external bus master. Each time the write pointer completes the lower half or the upper half of the memory, the block raises a notification pulse of programmable length. It also drives a bank flag that tells the master which half it may now copy out while the other half fills. A start input arms capture from address zero. A stop input halts it: a word that is already complete is still written, and a partial word is dropped.

Top module: `pingpong_capture_writer`

## Requirements
- R1: Only cycles with `bit_valid` high supply bits. The first accepted bit becomes bit WORD_W-1 of the word and the last accepted bit becomes bit 0. A word is formed only after WORD_W valid bits.
- R2: After start, completed words are written one per word to consecutive addresses, beginning at address 0.
- R3: After address DEPTH-1 (DEPTH = 2**ADDR_W) is written, the next word goes to address 0 and overwrites the older contents.
- R4: Writing address DEPTH/2-1 raises `half_done` with `half_sel` = 0 (lower half ready). Writing address DEPTH-1 raises it with `half_sel` = 1 (upper half ready).
- R5: Each notification keeps `half_done` high for exactly PULSE_LEN cycles and then drops it, so every half completion gives a new rising edge. `half_sel` stays constant while `half_done` is high.
- R6: A start pulse returns the write address to 0, discards any partly gathered bits and clears a pending notification. Bits offered in the start cycle are ignored.
- R7: A stop pulse ends capture. A word completed before the stop cycle is still written, a partial word is discarded, and bits offered while stopped change no memory location.
- R8: `rd_data` shows the memory word at `rd_addr` one clock after `rd_addr` is presented, independently of writing.
- R9: After reset the block is idle, `half_done` is 0 and `half_sel` is 0. The control state is one-hot, and all outputs are registered.
- R10: PULSE_LEN is at least 2 and smaller than the number of bit cycles in half the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Arm capture from address 0 |
| stop | input | 1 | Halt capture |
| bit_valid | input | 1 | Qualifies `bit_in` |
| bit_in | input | 1 | Serial data bit |
| rd_addr | input | ADDR_W | Read port address (bus master side) |
| rd_data | output | WORD_W | Registered read data |
| half_done | output | 1 | Half-completion notification pulse |
| half_sel | output | 1 | Completed half: 0 lower, 1 upper |

## Verification
The bench builds the block with ADDR_W = 3 and PULSE_LEN = 3, so the buffer holds eight words and each half holds four. With that size, twelve words are enough to complete both halves, wrap past the last address and overwrite the lower half, and they produce three notifications with the bank order 0, 1, 0. A short pulse length allows each pulse to be measured in full between half completions. It also leaves room for stop and restart scenarios that check partial-word discard against known memory contents.

// File: rtl/pcw_pkg.sv
package pcw_pkg;
  typedef enum logic [1:0] {
    CTL_IDLE = 2'b01,
    CTL_RUN  = 2'b10
  } ctl_state_t;
endpackage

// File: rtl/pcw_packer.sv
module pcw_packer #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              clr,
  input  logic              bit_valid,
  input  logic              bit_in,
  output logic [WORD_W-1:0] word,
  output logic              word_vld
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt      <= '0;
      word_vld <= 1'b0;
      shreg    <= '0;
    end else if (en && bit_valid) begin
      shreg <= {shreg[WORD_W-2:0], bit_in};
      if (cnt == LAST) begin
        cnt      <= '0;
        word     <= {shreg[WORD_W-2:0], bit_in};
        word_vld <= 1'b1;
      end else begin
        cnt      <= cnt + 1'b1;
        word_vld <= 1'b0;
      end
    end else begin
      word_vld <= 1'b0;
    end
  end

  // R1: a word only appears right after an accepted bit
  assert_word_from_bit_R1: assert property (@(posedge clk) disable iff (rst)
    word_vld |-> $past(en && bit_valid && !clr));
endmodule

// File: rtl/pcw_addr_ctrl.sv
module pcw_addr_ctrl
  import pcw_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              stop,
  input  logic              word_vld,
  output logic              running,
  output logic              we,
  output logic [ADDR_W-1:0] addr,
  output logic              evt_lo,
  output logic              evt_hi
);
  localparam logic [ADDR_W-1:0] HALF_LAST = {1'b0, {(ADDR_W-1){1'b1}}};
  localparam logic [ADDR_W-1:0] FULL_LAST = {ADDR_W{1'b1}};

  ctl_state_t state;

  assign running = (state == CTL_RUN);
  assign we      = running && word_vld && !start;
  assign evt_lo  = we && (addr == HALF_LAST);
  assign evt_hi  = we && (addr == FULL_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= CTL_IDLE;
      addr  <= '0;
    end else begin
      if (start) begin
        state <= CTL_RUN;
        addr  <= '0;
      end else begin
        if (we) addr <= addr + 1'b1;
        if (stop) state <= CTL_IDLE;
      end
    end
  end

  assert_onehot_state_R9: assert property (@(posedge clk) disable iff (rst)
    $countones(state) == 1);

  assert_wrap_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (we && addr == FULL_LAST) |=> (addr == '0));

  assert_idle_freeze_R7: assert property (@(posedge clk) disable iff (rst)
    (!running && !start) |=> $stable(addr));

  assert_start_zero_R6: assert property (@(posedge clk) disable iff (rst)
    start |=> (addr == '0 && running));
endmodule

// File: rtl/pcw_notify.sv
module pcw_notify #(
  parameter int PULSE_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic evt_lo,
  input  logic evt_hi,
  output logic irq,
  output logic bank
);
  localparam int CW = $clog2(PULSE_LEN + 1);
  localparam logic [CW-1:0] LOAD = CW'(PULSE_LEN - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      irq  <= 1'b0;
      bank <= 1'b0;
      cnt  <= '0;
    end else if (evt_lo || evt_hi) begin
      irq  <= 1'b1;
      bank <= evt_hi;
      cnt  <= LOAD;
    end else if (irq) begin
      if (cnt == '0) irq <= 1'b0;
      else           cnt <= cnt - 1'b1;
    end
  end

  // checker-side count of consecutive high cycles
  logic [CW:0] hi_run;
  always_ff @(posedge clk) begin
    if (rst || clr) hi_run <= '0;
    else if (irq)   hi_run <= hi_run + 1'b1;
    else            hi_run <= '0;
  end

  assert_pulse_len_R5: assert property (@(posedge clk) disable iff (rst)
    ($fell(irq) && !$past(clr)) |-> (hi_run == (CW+1)'(PULSE_LEN)));

  assert_bank_stable_R5: assert property (@(posedge clk) disable iff (rst)
    (irq && $past(irq)) |-> $stable(bank));

  assert_evt_raises_R4: assert property (@(posedge clk) disable iff (rst)
    (evt_lo && !clr) |=> (irq && !bank));
endmodule

// File: rtl/pcw_dpram.sv
module pcw_dpram #(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pingpong_capture_writer.sv
module pingpong_capture_writer #(
  parameter int WORD_W    = 32,
  parameter int ADDR_W    = 10,
  parameter int PULSE_LEN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              stop,
  input  logic              bit_valid,
  input  logic              bit_in,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic              half_done,
  output logic              half_sel
);
  localparam int HALF_BITS = (1 << (ADDR_W - 1)) * WORD_W;

  initial begin
    assert_param_pulse_R10: assert (PULSE_LEN >= 2 && PULSE_LEN < HALF_BITS)
      else $error("PULSE_LEN out of range");
  end

  logic              running, we, evt_lo, evt_hi, word_vld;
  logic [WORD_W-1:0] word;
  logic [ADDR_W-1:0] waddr;
  logic              pk_en, pk_clr;

  assign pk_en  = running && !start && !stop;
  assign pk_clr = start || stop || !running;

  pcw_packer #(.WORD_W(WORD_W)) u_packer (
    .clk(clk), .rst(rst), .en(pk_en), .clr(pk_clr),
    .bit_valid(bit_valid), .bit_in(bit_in),
    .word(word), .word_vld(word_vld)
  );

  pcw_addr_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .stop(stop),
    .word_vld(word_vld), .running(running), .we(we),
    .addr(waddr), .evt_lo(evt_lo), .evt_hi(evt_hi)
  );

  pcw_notify #(.PULSE_LEN(PULSE_LEN)) u_notify (
    .clk(clk), .rst(rst), .clr(start),
    .evt_lo(evt_lo), .evt_hi(evt_hi),
    .irq(half_done), .bank(half_sel)
  );

  pcw_dpram #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_ram (
    .clk(clk), .we(we), .waddr(waddr), .wdata(word),
    .raddr(rd_addr), .rdata(rd_data)
  );

  assert_reset_quiet_R9: assert property (@(posedge clk)
    $past(rst) |-> (!half_done && !half_sel));
endmodule

// File: tb/pingpong_capture_writer_test.sv
module pingpong_capture_writer_test;
  localparam int WW = 32;
  localparam int AW = 3;
  localparam int PL = 3;
  localparam int NV = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, stop = 1'b0, bit_valid = 1'b0, bit_in = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [WW-1:0] rd_data;
  logic half_done, half_sel;

  int checks = 0;
  int errors = 0;

  pingpong_capture_writer #(.WORD_W(WW), .ADDR_W(AW), .PULSE_LEN(PL)) uut (
    .clk(clk), .rst(rst), .start(start), .stop(stop),
    .bit_valid(bit_valid), .bit_in(bit_in), .rd_addr(rd_addr),
    .rd_data(rd_data), .half_done(half_done), .half_sel(half_sel)
  );

  always #10 clk = ~clk;

  // stimulus vectors: {gap_flag, word}
  localparam logic [WW:0] VEC [NV] = '{
    {1'b0, 32'hDEADBEEF}, {1'b1, 32'h80000001}, {1'b0, 32'h12345678},
    {1'b1, 32'hFFFF0000}, {1'b0, 32'h0F0F0F0F}, {1'b0, 32'hA5A5A5A5},
    {1'b1, 32'h00000001}, {1'b0, 32'hC0FFEE00}, {1'b0, 32'h13579BDF},
    {1'b1, 32'h2468ACE0}, {1'b0, 32'h7FFFFFFF}, {1'b0, 32'h55AA33CC}
  };

  task automatic chk(input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // notification monitor
  int rises = 0;
  int run_len = 0;
  logic banks [8];
  logic prev_irq = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (half_done && !prev_irq && rises < 8) begin
        banks[rises] = half_sel;
        rises++;
      end
      if (half_done) run_len++;
      else if (run_len > 0) begin
        chk("R5 pulse length", run_len, PL);
        run_len = 0;
      end
    end
    prev_irq = half_done;
  end

  task automatic pulse_start();
    @(negedge clk) start = 1'b1; bit_valid = 1'b1; bit_in = 1'b1;
    @(negedge clk) start = 1'b0; bit_valid = 1'b0;
  endtask

  task automatic send_bits(input logic [WW-1:0] w, input int n, input bit gap);
    for (int i = WW - 1; i >= WW - n; i--) begin
      @(negedge clk) bit_valid = 1'b1; bit_in = w[i];
      if (gap) begin
        @(negedge clk) bit_valid = 1'b0; bit_in = ~w[i];
      end
    end
  endtask

  task automatic idle_after();
    @(negedge clk) bit_valid = 1'b0;
  endtask

  task automatic rd_chk(input string req, input int a, input logic [WW-1:0] exp);
    @(negedge clk) rd_addr = AW'(a);
    @(negedge clk) chk(req, rd_data, exp);
  endtask

  initial begin
    repeat (2000 * 20) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 reset half_done", half_done, 0);
    chk("R9 reset half_sel", half_sel, 0);
    @(negedge clk) rst = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 idle no pulse", half_done, 0);

    // main table: R1 R2 R3 R4
    pulse_start();
    for (int v = 0; v < NV; v++) begin
      send_bits(VEC[v][WW-1:0], WW, VEC[v][WW]);
      idle_after();
      if (v == 2) chk("R4 no pulse before half", rises, 0);
    end
    repeat (PL + 3) @(negedge clk);
    chk("R4 three notifications", rises, 3);
    chk("R4 first bank lower", banks[0], 0);
    chk("R4 second bank upper", banks[1], 1);
    chk("R4 third bank lower after wrap", banks[2], 0);
    for (int a = 0; a < 4; a++) rd_chk("R3 wrap overwrite", a, VEC[a + 8][WW-1:0]);
    for (int a = 4; a < 8; a++) rd_chk("R2 R1 packed word", a, VEC[a][WW-1:0]);

    // R7: stop in the cycle after a word completes keeps that word
    pulse_start();
    send_bits(32'hCAFEF00D, WW, 1'b0);
    @(negedge clk) bit_valid = 1'b0; stop = 1'b1;
    @(negedge clk) stop = 1'b0;
    send_bits(32'h99999999, WW, 1'b0);   // offered while stopped
    idle_after();
    repeat (2) @(negedge clk);
    rd_chk("R7 completed word kept", 0, 32'hCAFEF00D);
    rd_chk("R7 stopped bits ignored", 1, VEC[9][WW-1:0]);

    // R6/R7: partial word discarded, start returns to address 0
    pulse_start();
    send_bits(32'hFFFFFFFF, 16, 1'b0);
    idle_after();
    @(negedge clk) stop = 1'b1;
    @(negedge clk) stop = 1'b0;
    pulse_start();
    send_bits(32'h3C3C1234, WW, 1'b1);
    idle_after();
    repeat (2) @(negedge clk);
    rd_chk("R6 start at address 0, partial dropped", 0, 32'h3C3C1234);
    rd_chk("R6 next address untouched", 1, VEC[9][WW-1:0]);
    chk("R5 no extra notifications", rises, 3);

    // R8: read port reflects memory with one cycle latency
    @(negedge clk) rd_addr = AW'(5);
    @(negedge clk) rd_addr = AW'(6);
    chk("R8 read latency first", rd_data, VEC[5][WW-1:0]);
    @(negedge clk) chk("R8 read latency second", rd_data, VEC[6][WW-1:0]);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule